// File: doc/BRIEF.md
# EEPROM Page-Write Programmer

This block is the host-side sequencer that commits one page of a write-protected, page-organised parallel memory. A single start pulse selects a page and a completion-detection method. The block then clocks in up to one page of bytes over a valid/ready stream and produces the memory's address, write data and active-low chip, output and write strobes by itself. Before any page data it sends the three-step unlock preamble. It writes each accepted byte to the next column of the page. It then leaves the bus quiet long enough for the device to start its internal programming. Finally it reads the device back until the read-back shows that programming has finished.

Two completion methods are available. The first compares bit 6 across two reads in a row, because that bit toggles while the device is busy. The second checks bit 7 at the last written location, because the device returns that bit inverted while busy. A programming cycle can take many thousands of polls, so the poll loop is bounded only by a parameterised watchdog. When the watchdog runs out, the block finishes with an error flag instead of hanging. Completion is reported by a one-cycle `done` pulse.

Top module: `eeprom_page_programmer`

## Requirements
- R1: While in reset and after reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, and `s_ready`, `busy`, `done` and `error` are low.
- R2: After a start, the first three bus writes are, in this order: data AAh at address 5555h, data 55h at address 2AAAh, and data A0h at address 5555h.
- R3: Page data byte n goes to address {page, n}. The page number fills the upper 9 address bits and the column fills the lower 7 bits. The column starts at 0 and rises by one for each accepted stream beat (`s_valid` && `s_ready`).
- R4: Loading ends after the beat that carries `s_last`, or after the 128th beat, whichever comes first. `s_ready` is high only while the block waits for a data byte, so no further beats are accepted.
- R5: Every write holds `mem_ce_n` and `mem_we_n` low, with `mem_oe_n` high, for exactly WE_CYCLES clocks. Every poll read holds `mem_ce_n` and `mem_oe_n` low, with `mem_we_n` high, for exactly RD_CYCLES clocks. Write and read strobes never overlap.
- R6: Between the end of the last write and the start of the first poll read, the bus stays idle for at least LOAD_GAP clocks.
- R7: Every poll read uses the address of the last byte loaded.
- R8: With `poll_mode` = 0 (toggle polling), the block finishes at the end of the first read whose bit 6 equals bit 6 of the read just before it.
- R9: With `poll_mode` = 1 (inverted-data polling), the block finishes at the end of the first read whose bit 7 equals bit 7 of the last byte written.
- R10: If no completion is seen within POLL_MAX clocks of polling, the block finishes with `error` high. `error` then stays high until the next accepted start. A successful finish leaves `error` low.
- R11: `busy` is high from the clock after an accepted start until the finish. `done` is a single-cycle pulse, and `busy` is low while it is asserted. A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin programming one page |
| page | input | 9 | Page number, sampled at start |
| poll_mode | input | 1 | 0 = toggle polling, 1 = inverted-data polling |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a short page |
| s_ready | output | 1 | Block accepts a stream byte |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last job ended by watchdog |

## Verification
The bench targets four kinds of mistake. The first is the toggle-poll parity corner. Depending on how many busy reads occur and on the final bit 6 of the data, completion falls on either the first or the second settled read. A design that compared against a stale or unreset previous sample would finish one read early or late, or would treat the very first read as complete.

The second is page-boundary handling. After a full 128-byte page the stream keeps offering bytes, so a design that wrapped the column or kept `s_ready` high would issue an unexpected write. A short page ended by `s_last` must poll the last address actually loaded, not column 127.

The third is the watchdog. It must raise `error` and hold it only until the next start. The fourth is a start pulse during a job, which would restart the unlock sequence in a design that failed to ignore it.

// File: rtl/eeprom_page_programmer.sv
module eeprom_page_programmer #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  parameter int WE_CYCLES  = 2,
  parameter int RD_CYCLES  = 2,
  parameter int LOAD_GAP   = 8,
  parameter int POLL_MAX   = 1000000,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 'h5555,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 'h2AAA,
  localparam int COL_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page,
  input  logic              poll_mode,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int CNT_MAX = ((WE_CYCLES > RD_CYCLES) ? WE_CYCLES : RD_CYCLES) > LOAD_GAP ?
                           ((WE_CYCLES > RD_CYCLES) ? WE_CYCLES : RD_CYCLES) : LOAD_GAP;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int WD_W  = $clog2(POLL_MAX + RD_CYCLES + 2);
  localparam logic [CNT_W-1:0] WE_END  = CNT_W'(WE_CYCLES);
  localparam logic [CNT_W-1:0] RD_END  = CNT_W'(RD_CYCLES);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_END = CNT_W'(LOAD_GAP - 1);
  localparam logic [COL_W-1:0] COL_END = COL_W'(PAGE_BYTES - 1);
  localparam logic [WD_W-1:0]  WD_LIM  = WD_W'(POLL_MAX);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WR, S_GAP, S_RD} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         step;
  logic [COL_W-1:0]   col;
  logic [PAGE_W-1:0]  page_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         data_q;
  logic               last_q, mode_q, prev6, seen, hit_q;
  logic [WD_W-1:0]    wd;
  logic               hit, unused_rd;

  assign unused_rd = ^mem_rdata[5:0];
  assign hit = mode_q ? (mem_rdata[7] == data_q[7]) : (seen && mem_rdata[6] == prev6);

  assign mem_we_n  = !(st == S_WR && cnt < WE_END);
  assign mem_oe_n  = !(st == S_RD && cnt < RD_END);
  assign mem_ce_n  = mem_we_n & mem_oe_n;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign s_ready   = (st == S_LOAD);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; step <= '0; col <= '0; page_q <= '0;
      addr_q <= '0; data_q <= '0; last_q <= 1'b0; mode_q <= 1'b0;
      prev6 <= 1'b0; seen <= 1'b0; hit_q <= 1'b0; wd <= '0;
      done <= 1'b0; error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          page_q <= page; mode_q <= poll_mode; error <= 1'b0;
          step <= 2'd1; addr_q <= UNLOCK_A; data_q <= 8'hAA;
          col <= '0; cnt <= '0; st <= S_WR;
        end
        S_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == WE_END) begin
            cnt <= '0;
            case (step)
              2'd1: begin step <= 2'd2; addr_q <= UNLOCK_B; data_q <= 8'h55; end
              2'd2: begin step <= 2'd3; addr_q <= UNLOCK_A; data_q <= 8'hA0; end
              2'd3: begin step <= 2'd0; st <= S_LOAD; end
              default: if (last_q) st <= S_GAP;
                       else begin col <= col + 1'b1; st <= S_LOAD; end
            endcase
          end
        end
        S_LOAD: if (s_valid) begin
          addr_q <= {page_q, col}; data_q <= s_data;
          last_q <= s_last || (col == COL_END);
          cnt <= '0; st <= S_WR;
        end
        S_GAP: begin
          cnt <= cnt + 1'b1;
          if (cnt == GAP_END) begin
            cnt <= '0; wd <= '0; seen <= 1'b0; st <= S_RD;
          end
        end
        S_RD: begin
          cnt <= cnt + 1'b1;
          wd  <= wd + 1'b1;
          if (cnt == RD_LAST) begin
            hit_q <= hit; prev6 <= mem_rdata[6]; seen <= 1'b1;
          end
          if (cnt == RD_END) begin
            cnt <= '0;
            if (hit_q) begin
              st <= S_IDLE; done <= 1'b1;
            end else if (wd >= WD_LIM) begin
              st <= S_IDLE; done <= 1'b1; error <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_page_programmer_chk.sv
module eeprom_page_programmer_chk #(
  parameter int WE_CYCLES = 2,
  parameter int RD_CYCLES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic s_ready,
  input logic busy,
  input logic done,
  input logic error
);
  logic [7:0] we_lo, oe_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo <= '0; oe_lo <= '0;
    end else begin
      we_lo <= mem_we_n ? 8'd0 : we_lo + 8'd1;
      oe_lo <= mem_oe_n ? 8'd0 : oe_lo + 8'd1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_we_n && !mem_oe_n)); // R5
  AST_CE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n || !mem_oe_n) |-> !mem_ce_n); // R5
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> we_lo == 8'(WE_CYCLES)); // R5
  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_oe_n) |-> oe_lo == 8'(RD_CYCLES)); // R5
  AST_READY_IN_JOB: assert property (@(posedge clk) disable iff (!rst_n) s_ready |-> busy && mem_ce_n); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R11
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) error && !start |=> error); // R10
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(error) |-> done); // R10
endmodule

bind eeprom_page_programmer eeprom_page_programmer_chk #(
  .WE_CYCLES(WE_CYCLES), .RD_CYCLES(RD_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .s_ready(s_ready), .busy(busy), .done(done), .error(error)
);

// File: tb/eeprom_page_programmer_tb.sv
module eeprom_page_programmer_tb;
  localparam int WE_C = 2, RD_C = 2, GAP = 6, PMAX = 600, PB = 128;

  logic clk = 0, rst_n = 0, start = 0, poll_mode = 0;
  logic [8:0] page = '0;
  logic s_valid = 0, s_last = 0;
  logic [7:0] s_data = '0;
  logic s_ready, mem_ce_n, mem_oe_n, mem_we_n, busy, done, error;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  eeprom_page_programmer #(.WE_CYCLES(WE_C), .RD_CYCLES(RD_C), .LOAD_GAP(GAP), .POLL_MAX(PMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .poll_mode(poll_mode),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .busy(busy), .done(done), .error(error));

  int n_chk = 0, n_fail = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  int busy_left = 0, reads = 0;
  logic tog = 0, first_rd = 1;
  logic [7:0] lastd = '0;
  logic [15:0] exp_poll = '0;

  assign mem_rdata = (busy_left > 0) ? {~lastd[7], tog, lastd[5:0]} : lastd;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [8:0] pg, input int i);
    return 8'(pg * 5 + i * 29 + 3);
  endfunction

  // monitor: bus scoreboard and device model
  logic pwe = 1, poe = 1;
  int we_lo = 0, oe_lo = 0, idle_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) begin
        we_lo++;
        chk(!mem_ce_n && mem_oe_n, "R5", "strobes during write", {mem_ce_n, mem_oe_n}, 2'b01);
      end
      if (!mem_oe_n) begin
        oe_lo++;
        chk(!mem_ce_n && mem_we_n, "R5", "strobes during read", {mem_ce_n, mem_we_n}, 2'b01);
        if (poe) begin
          chk(mem_addr == exp_poll, "R7", "poll address", mem_addr, exp_poll);
          if (first_rd) chk(idle_run >= GAP, "R6", "idle gap before poll", idle_run, GAP);
          first_rd = 0;
        end
      end
      if (mem_we_n && !pwe) begin
        chk(we_lo == WE_C, "R5", "write pulse width", we_lo, WE_C);
        if (exp_q.size() == 0) chk(0, "R4", "unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk({mem_addr, mem_wdata} == e, t, "write addr/data", {mem_addr, mem_wdata}, e);
        end
        we_lo = 0;
      end
      if (mem_oe_n && !poe) begin
        chk(oe_lo == RD_C, "R5", "read pulse width", oe_lo, RD_C);
        oe_lo = 0; reads++;
        if (busy_left > 0) begin busy_left--; tog = ~tog; end
      end
      if (mem_we_n && mem_oe_n) idle_run++; else idle_run = 0;
      pwe = mem_we_n; poe = mem_oe_n;
    end
  end

  task automatic run_job(input logic [8:0] pg, input logic md, input int n, input int bsy,
                         input bit use_last, input bit want_err, input bit poke);
    int exp_reads;
    bit got;
    busy_left = bsy; tog = 0; reads = 0; first_rd = 1;
    exp_q.push_back({16'h5555, 8'hAA}); tag_q.push_back("R2");
    exp_q.push_back({16'h2AAA, 8'h55}); tag_q.push_back("R2");
    exp_q.push_back({16'h5555, 8'hA0}); tag_q.push_back("R2");
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({pg, 7'(i), pat(pg, i)}); tag_q.push_back("R3");
    end
    lastd = pat(pg, n - 1);
    exp_poll = {pg, 7'(n - 1)};
    if (md) exp_reads = bsy + 1;
    else if (bsy == 0) exp_reads = 2;
    else exp_reads = (((bsy - 1) % 2) == int'(lastd[6])) ? bsy + 1 : bsy + 2;

    @(negedge clk); start = 1; page = pg; poll_mode = md;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    for (int i = 0; i < n; i++) begin
      if (i % 5 == 3) begin s_valid = 0; repeat (2) @(negedge clk); end
      s_valid = 1; s_data = pat(pg, i); s_last = use_last && (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_last = 0;
    if (n == PB && !use_last) begin s_valid = 1; s_data = 8'hEE; end
    else s_valid = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; page = ~pg; @(negedge clk); start = 0;
    end
    got = 0;
    for (int w = 0; w < 20000 && !got; w++) begin
      if (done) got = 1; else @(negedge clk);
    end
    chk(got, "R11", "done seen", got, 1);
    chk(error == want_err, want_err ? "R10" : (md ? "R9" : "R8"), "error at done", error, want_err);
    if (!want_err) chk(reads == exp_reads, md ? "R9" : "R8", "poll read count", reads, exp_reads);
    chk(busy == 1'b0, "R11", "busy low at done", busy, 0);
    chk(exp_q.size() == 0, "R3", "all writes issued", exp_q.size(), 0);
    chk(s_ready == 1'b0, "R4", "ready low after load", s_ready, 0);
    s_valid = 0;
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", done, 0);
    chk(error == want_err, "R10", "error held", error, want_err);
    busy_left = 0; exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes idle", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(!s_ready && !busy && !done && !error, "R1", "flags idle", {s_ready, busy, done, error}, 0);
    run_job(9'h005, 1'b1, 128, 5, 1'b0, 1'b0, 1'b0);
    run_job(9'h1A3, 1'b0, 10, 4, 1'b1, 1'b0, 1'b1);
    run_job(9'h000, 1'b0, 1, 0, 1'b1, 1'b0, 1'b0);
    run_job(9'h1FF, 1'b0, 3, 7, 1'b1, 1'b0, 1'b0);
    run_job(9'h042, 1'b1, 20, 100000, 1'b1, 1'b1, 1'b0);
    run_job(9'h011, 1'b1, 2, 1, 1'b1, 1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule